// File: doc/BRIEF.md
# Sequential Prefetch Read Buffer

The block sits between a host read port and a slower 32-bit local bus that delivers data from a detector's parallel output. A host read that cannot be served from buffered data starts a speculative burst on the local bus. The fetcher then drives a run of consecutive word addresses, one strobe per cycle, and does not wait for further host requests. The returning words go into a 16-entry FIFO. Host reads that carry on at the next sequential word address are answered from the head of that FIFO, in fetch order.

A read at any other address throws away the buffered words and the rest of the running burst, and starts a new burst at the requested address. When a sequential run has drained the FIFO and the burst has finished, the next sequential read starts a fresh burst at the following address. A host that reads one word and then jumps elsewhere therefore gets plain single-word transfers. Both sides run on one clock.

Top module: `burst_prefetch_buf`

## Requirements
- R1: Reset (active-low rst_ni) empties the FIFO, clears the expected address and idles the fetcher. After reset, host_valid_o and lb_rd_o stay low until a host request arrives, and the first request always waits for a new burst.
- R2: A burst driven from start address S drives exactly 16 strobes on consecutive cycles with addresses S, S+1, … S+15, taken modulo 2^28. The first strobe comes in the cycle after the request that started the burst.
- R3: lb_data_i is taken as the word for the address strobed one cycle earlier, and words are queued in strobe order.
- R4: While host_req_i is high, host_addr_i equals the expected address and the FIFO is not empty, host_valid_o is high in that same cycle. host_data_o then carries the head word, the word is consumed at the clock edge, and the expected address advances by one.
- R5: A request that starts a burst sees host_valid_o first in the third cycle after the request cycle.
- R6: A request at a non-expected address discards the buffered words. The old burst issues no further strobe, from the request cycle onward. The new burst starts at the requested address, and no old word is delivered.
- R7: Once a sequential run has emptied the FIFO and its burst is complete, the next request at the expected address starts a new 16-word burst from that address.
- R8: host_valid_o is low whenever host_req_i is low, the address mismatches, or the FIFO is empty. The host is stalled until a valid cycle.
- R9: The FIFO never holds more than 16 words and is never read while empty.
- R10: Isolated single-word reads at unrelated addresses each return the correct word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by host and local bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_req_i | input | 1 | Host read request, held until valid |
| host_addr_i | input | 28 | Host word address |
| host_data_o | output | 32 | Read data, meaningful while host_valid_o is high |
| host_valid_o | output | 1 | Requested word is present; consumed this cycle |
| lb_rd_o | output | 1 | Local-bus read strobe |
| lb_addr_o | output | 28 | Local-bus word address |
| lb_data_i | input | 32 | Local-bus read data, one cycle after the strobe |

## Verification
A stale expected address or leftover FIFO entries show up at the ports within one cycle. The host either gets an immediate valid where a three-cycle wait was due, or gets a word belonging to another address. A broken burst counter or fetch address shows up in the strobe trace as a burst longer or shorter than 16, or as an address gap. A missing flush shows up at the next sequential read, which returns an old-stream word. Every host word is compared against a value computed from its address, so a mis-ordered or mis-aligned capture is caught at the first read that returns it.

// File: rtl/pfb_pkg.sv
`timescale 1ns/1ps
package pfb_pkg;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned ADDR_W_DEF = 28;
  localparam int unsigned DEPTH_DEF  = 16;

  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_RUN  = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/pfb_fifo.sv
`timescale 1ns/1ps
module pfb_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && !flush_i;
  assign do_pop  = pop_i && !flush_i;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_push |-> (!full_o || do_pop));
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pop |-> !empty_o);
endmodule

// File: rtl/pfb_fetch.sv
`timescale 1ns/1ps
module pfb_fetch
  import pfb_pkg::*;
#(
  parameter int unsigned AW    = 28,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          lb_rd_o,
  output logic [AW-1:0] lb_addr_o,
  output logic          push_o,
  output logic          busy_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  fetch_state_e  state_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] issued_q;
  logic          rd_q;

  // a restart kills the strobe and the capture of the cycle it arrives in
  assign lb_rd_o   = (state_q == FETCH_RUN) && !start_i;
  assign lb_addr_o = addr_q;
  assign push_o    = rd_q && !start_i;
  assign busy_o    = (state_q == FETCH_RUN) || rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FETCH_IDLE;
      addr_q   <= '0;
      issued_q <= '0;
      rd_q     <= 1'b0;
    end else if (start_i) begin
      state_q  <= FETCH_RUN;
      addr_q   <= start_addr_i;
      issued_q <= '0;
      rd_q     <= 1'b0;
    end else begin
      rd_q <= lb_rd_o;
      if (lb_rd_o) begin
        addr_q   <= addr_q + 1'b1;
        issued_q <= issued_q + 1'b1;
        if (issued_q == CW'(DEPTH - 1)) state_q <= FETCH_IDLE;
      end
    end
  end

  assert_strobe_consecutive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_rd_o && $past(lb_rd_o)) |-> (lb_addr_o == $past(lb_addr_o) + 1'b1));
  assert_capture_after_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(lb_rd_o));
endmodule

// File: rtl/burst_prefetch_buf.sv
`timescale 1ns/1ps
module burst_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_valid_o,
  output logic              lb_rd_o,
  output logic [ADDR_W-1:0] lb_addr_o,
  input  logic [DATA_W-1:0] lb_data_i
);
  logic [ADDR_W-1:0] exp_addr_q;
  logic              addr_match, hit, start;
  logic              fifo_push, fifo_empty, fifo_full, fetch_busy;

  assign addr_match = (host_addr_i == exp_addr_q);
  assign hit        = host_req_i && addr_match && !fifo_empty;
  // restart on a jump, or on a sequential read once the buffer and burst are spent
  assign start      = host_req_i && !hit && (!addr_match || (fifo_empty && !fetch_busy));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    exp_addr_q <= '0;
    else if (start) exp_addr_q <= host_addr_i;
    else if (hit)   exp_addr_q <= exp_addr_q + 1'b1;
  end

  pfb_fetch #(.AW(ADDR_W), .DEPTH(DEPTH)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_addr_i (host_addr_i),
    .lb_rd_o      (lb_rd_o),
    .lb_addr_o    (lb_addr_o),
    .push_o       (fifo_push),
    .busy_o       (fetch_busy)
  );

  pfb_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (start),
    .push_i  (fifo_push),
    .wdata_i (lb_data_i),
    .pop_i   (hit),
    .rdata_o (host_data_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign host_valid_o = hit;

  assert_valid_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_valid_o |-> host_req_i);
  assert_start_strobes_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (start || (lb_rd_o && lb_addr_o == $past(host_addr_i))));
  assert_fill_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_push && !start) |-> (!fifo_full || hit));
endmodule

// File: tb/burst_prefetch_buf_tb_top.sv
`timescale 1ns/1ps
module burst_prefetch_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_req = 1'b0;
  logic [27:0] host_addr = '0;
  logic [31:0] host_data;
  logic        host_valid;
  logic        lb_rd;
  logic [27:0] lb_addr;
  logic [31:0] lb_data = 32'hDEAD_BEEF;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  logic [27:0] lb_log[$];

  always #2 clk = ~clk;

  burst_prefetch_buf dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_req_i(host_req), .host_addr_i(host_addr),
    .host_data_o(host_data), .host_valid_o(host_valid),
    .lb_rd_o(lb_rd), .lb_addr_o(lb_addr), .lb_data_i(lb_data)
  );

  function automatic logic [31:0] word_of(input logic [27:0] a);
    return ({4'h0, a} * 32'h0001_0003) ^ 32'hC3A5_0F1E;
  endfunction

  // local device: one-cycle read latency, junk when not strobed
  always @(posedge clk) lb_data <= lb_rd ? word_of(lb_addr) : 32'hDEAD_BEEF;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // strobe logger and scoreboard monitor, both sampled mid-cycle
  initial forever begin
    @(negedge clk); #1;
    if (rst_ni && lb_rd) lb_log.push_back(lb_addr);
    if (rst_ni && host_req && host_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected valid", host_data, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(host_data == e, "R4 data order", host_data, e);
      end
    end
  end

  task automatic host_read(input logic [27:0] a, output int waits, output int mark);
    exp_q.push_back(word_of(a));
    @(negedge clk);
    host_req = 1'b1; host_addr = a;
    mark = lb_log.size();
    waits = 0;
    #1;
    while (!host_valid && waits < 50) begin
      @(negedge clk); #1; waits++;
    end
    if (waits >= 50) check(1'b0, "R8 host read hung", waits, 3);
  endtask

  task automatic idle(input int n);
    @(negedge clk); host_req = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic check_log(input int from, input logic [27:0] base, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [27:0] ea;
      ea = base + 28'(i);
      if (from + i >= lb_log.size()) begin
        check(1'b0, tag, -1, ea);
        return;
      end
      check(lb_log[from + i] == ea, tag, lb_log[from + i], ea);
    end
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w, m, m16, mb;
    logic [27:0] a, b;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(host_valid == 1'b0, "R1 valid low after reset", host_valid, 0);
    check(lb_rd == 1'b0, "R1 no strobe after reset", lb_rd, 0);

    // cold sequential run
    a = 28'h000_1000;
    host_read(a, w, m);
    check(w == 3, "R5 first-word latency", w, 3);
    for (int i = 1; i < 16; i++) begin
      host_read(a + 28'(i), w, m);
      check(w == 0, "R4 sequential hit no stall", w, 0);
    end
    idle(20);
    check(lb_log.size() == 16, "R2 burst length", lb_log.size(), 16);
    check_log(0, a, 16, "R2 burst addresses");

    // drained buffer: refill from next address
    host_read(a + 28'd16, w, m16);
    check(w == 3, "R7 refill latency", w, 3);
    host_read(a + 28'd17, w, m);
    check(w == 0, "R3 refill words queued", w, 0);

    // jump: old burst cut, new burst from jump address
    b = 28'h0ABC_DE0;
    host_read(b, w, mb);
    check(w == 3, "R6 jump restarts fetch", w, 3);
    check(mb - m16 == 4, "R6 old burst cut short", mb - m16, 4);
    host_read(b + 28'd1, w, m);
    host_read(b + 28'd2, w, m);
    idle(24);
    check(lb_log.size() - mb == 16, "R6 new burst length", lb_log.size() - mb, 16);
    check_log(mb, b, 16, "R6 new burst addresses");

    // isolated single-word reads
    host_read(28'h123_4567, w, m);
    check(w == 3, "R10 single read A", w, 3);
    host_read(28'h000_0042, w, m);
    check(w == 3, "R10 single read B", w, 3);
    host_read(28'hF00_0F00, w, m);
    check(w == 3, "R10 single read C", w, 3);
    idle(2);
    #1;
    check(host_valid == 1'b0, "R8 no valid without request", host_valid, 0);

    // address wrap
    host_read(28'hFFF_FFFF, w, m);
    check(w == 3, "R2 wrap start latency", w, 3);
    host_read(28'h000_0000, w, m);
    check(w == 0, "R2 wrap continues sequence", w, 0);
    idle(24);

    // reset mid-burst empties everything
    host_read(28'h055_5500, w, m);
    idle(1);
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    #1;
    check(lb_rd == 1'b0, "R1 fetch idle after reset", lb_rd, 0);
    host_read(28'h055_5501, w, m);
    check(w == 3, "R1 buffer emptied by reset", w, 3);
    idle(24);

    check(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule